// File: doc/BRIEF.md
# Banked Effective Address Generator

This block computes the 20-bit effective address for a 16-bit processor whose address space is split into sixteen 64-Kbyte banks. Each 16-bit pointer (three index registers and the program counter) has a 4-bit bank field beside it. An offset, an accumulator or an address word taken from the instruction is combined with the chosen pointer. A carry or borrow out of the low 16 bits of an indexed sum moves into the bank bits.

One request is issued per cycle by raising `valid_i`, together with a mode code and its operands. The address is registered and appears one clock later with `ea_valid_o`. In post-modify mode the block issues the unmodified X pointer as the address. On the same output cycle it presents the stepped X value on a separate write port, which the register file captures at the following edge. No bank field is ever written back.

Top module: `bank_ea_gen`

## Requirements
- R1: A request taken with `valid_i` high at a rising edge yields `ea_o` and `ea_valid_o`=1 (and the post-modify write port) right after that edge. With `valid_i` low, `ea_valid_o` is 0 after the edge.
- R2: Mode 0 (extended): `ea_o` = {`ek_i`, `ofs_i[15:0]`}.
- R3: Mode 1: `ofs_i[7:0]` is zero-extended and added to the 20-bit {bank, index} value, modulo 2^20. A carry out of bit 15 increments the bank bits.
- R4: Mode 2: `ofs_i[15:0]` is sign-extended (bit 15 is the sign) and added to the 20-bit {bank, index} value, modulo 2^20. A borrow decrements the bank bits.
- R5: Mode 3: `ofs_i[19:0]` is taken as a signed 20-bit value (bit 19 is the sign) and added to the 20-bit {bank, index} value, modulo 2^20.
- R6: Mode 4: `acc_i` is zero-extended and added to the 20-bit {bank, index} value, modulo 2^20.
- R7: Modes 5 and 6 (relative, byte and word): when `taken_i`=1, `ea_o` = {`pk_i`, `pc_i` + offset mod 2^16}. Mode 5 uses sign-extended `ofs_i[7:0]` and mode 6 uses `ofs_i[15:0]`. The bank bits always equal `pk_i`. When `taken_i`=0, `ea_o` = {`pk_i`, `pc_i`}.
- R8: Mode 7 (post-modify): `ea_o` = {`xk_i`, `ix_i`} regardless of `idx_sel_i`. `xwr_en_o`=1 and `xwr_data_o` = `ix_i` + sign-extended `ofs_i[7:0]`, modulo 2^16. In every other mode `xwr_en_o`=0.
- R9: In modes 1 to 4, `idx_sel_i`=0 selects {`xk_i`,`ix_i`} and 1 selects {`yk_i`,`iy_i`}. A value of 2 or 3 selects {`zk_i`,`iz_i`}.
- R10: A cycle with `valid_i` low leaves `ea_o` unchanged and gives `ea_valid_o`=0 and `xwr_en_o`=0, whatever the other inputs are.
- R11: While `rst_n` is low, `ea_o`, `ea_valid_o`, `xwr_en_o` and `xwr_data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Address mode code (0 to 7) |
| idx_sel_i | input | 2 | Index register choice for modes 1 to 4 |
| ix_i | input | 16 | Index register X |
| xk_i | input | 4 | Bank field of X |
| iy_i | input | 16 | Index register Y |
| yk_i | input | 4 | Bank field of Y |
| iz_i | input | 16 | Index register Z |
| zk_i | input | 4 | Bank field of Z |
| acc_i | input | 16 | Accumulator used as offset |
| pc_i | input | 16 | Program counter |
| pk_i | input | 4 | Program bank field |
| ek_i | input | 4 | Extended-mode bank field |
| ofs_i | input | 20 | Offset operand or address word |
| taken_i | input | 1 | Branch condition result |
| ea_o | output | 20 | Effective address |
| ea_valid_o | output | 1 | Effective address valid |
| xwr_en_o | output | 1 | Write enable for stepped X |
| xwr_data_o | output | 16 | Stepped X value |

## Verification
Every result of this block is due exactly one rising edge after the request is taken. This covers the address, its valid flag and the stepped X write port. The bench therefore changes inputs on the falling edge and compares all outputs on the next falling edge, half a cycle after the capturing edge. After each request it runs one idle cycle with scrambled operands and compares again at the following falling edge, to confirm the held address and the cleared strobes. The sweep covers every mode and every index choice, with boundary pointer, bank and offset values that force bank carries, borrows and 16-bit wraps.

// File: rtl/bank_ea_gen.sv
module bank_ea_gen #(
  parameter int AW = 16,
  parameter int KW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       idx_sel_i,
  input  logic [AW-1:0]    ix_i,
  input  logic [KW-1:0]    xk_i,
  input  logic [AW-1:0]    iy_i,
  input  logic [KW-1:0]    yk_i,
  input  logic [AW-1:0]    iz_i,
  input  logic [KW-1:0]    zk_i,
  input  logic [AW-1:0]    acc_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [KW-1:0]    pk_i,
  input  logic [KW-1:0]    ek_i,
  input  logic [AW+KW-1:0] ofs_i,
  input  logic             taken_i,
  output logic [AW+KW-1:0] ea_o,
  output logic             ea_valid_o,
  output logic             xwr_en_o,
  output logic [AW-1:0]    xwr_data_o
);
  localparam int EW = AW + KW;
  localparam logic [2:0] M_EXT   = 3'd0;
  localparam logic [2:0] M_IDX8  = 3'd1;
  localparam logic [2:0] M_IDX16 = 3'd2;
  localparam logic [2:0] M_IDX20 = 3'd3;
  localparam logic [2:0] M_ACC   = 3'd4;
  localparam logic [2:0] M_REL8  = 3'd5;
  localparam logic [2:0] M_REL16 = 3'd6;
  localparam logic [2:0] M_POST  = 3'd7;

  logic [EW-1:0] base, ea_d;
  wire  [EW-1:0] off8u  = EW'(ofs_i[7:0]);
  wire  [EW-1:0] off16s = {{KW{ofs_i[AW-1]}}, ofs_i[AW-1:0]};
  wire  [EW-1:0] accu   = EW'(acc_i);
  wire  [AW-1:0] sx8    = {{(AW-8){ofs_i[7]}}, ofs_i[7:0]};
  wire  [AW-1:0] pc_b   = taken_i ? pc_i + sx8 : pc_i;
  wire  [AW-1:0] pc_w   = taken_i ? pc_i + ofs_i[AW-1:0] : pc_i;

  always_comb begin
    case (idx_sel_i)
      2'd0:    base = {xk_i, ix_i};
      2'd1:    base = {yk_i, iy_i};
      default: base = {zk_i, iz_i};
    endcase
  end

  always_comb begin
    case (mode_i)
      M_EXT:   ea_d = {ek_i, ofs_i[AW-1:0]};
      M_IDX8:  ea_d = base + off8u;
      M_IDX16: ea_d = base + off16s;
      M_IDX20: ea_d = base + ofs_i;
      M_ACC:   ea_d = base + accu;
      M_REL8:  ea_d = {pk_i, pc_b};
      M_REL16: ea_d = {pk_i, pc_w};
      default: ea_d = {xk_i, ix_i};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_o       <= '0;
      ea_valid_o <= 1'b0;
      xwr_en_o   <= 1'b0;
      xwr_data_o <= '0;
    end else begin
      ea_valid_o <= valid_i;
      xwr_en_o   <= valid_i && (mode_i == M_POST);
      if (valid_i) begin
        ea_o       <= ea_d;
        xwr_data_o <= ix_i + sx8;
      end
    end
  end

  p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> ea_valid_o);
  p_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && mode_i == M_EXT |=> ea_o == {$past(ek_i), $past(ofs_i[AW-1:0])});
  p_rel_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (mode_i == M_REL8 || mode_i == M_REL16) |=> ea_o[EW-1:AW] == $past(pk_i));
  p_rel_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (mode_i == M_REL8 || mode_i == M_REL16) && !taken_i
      |=> ea_o == {$past(pk_i), $past(pc_i)});
  p_post_ea_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && mode_i == M_POST |=> ea_o == {$past(xk_i), $past(ix_i)} && xwr_en_o);
  p_no_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && mode_i != M_POST |=> !xwr_en_o);
  p_wr_with_ea_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xwr_en_o |-> ea_valid_o);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(ea_o) && !ea_valid_o && !xwr_en_o);
endmodule

// File: tb/bank_ea_gen_tb.sv
module bank_ea_gen_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, valid_i, taken_i;
  logic [2:0] mode_i;
  logic [1:0] idx_sel_i;
  logic [15:0] ix_i, iy_i, iz_i, acc_i, pc_i;
  logic [3:0] xk_i, yk_i, zk_i, pk_i, ek_i;
  logic [19:0] ofs_i;
  logic [19:0] ea_o;
  logic ea_valid_o, xwr_en_o;
  logic [15:0] xwr_data_o;

  bank_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .idx_sel_i(idx_sel_i), .ix_i(ix_i), .xk_i(xk_i), .iy_i(iy_i), .yk_i(yk_i),
    .iz_i(iz_i), .zk_i(zk_i), .acc_i(acc_i), .pc_i(pc_i), .pk_i(pk_i),
    .ek_i(ek_i), .ofs_i(ofs_i), .taken_i(taken_i), .ea_o(ea_o),
    .ea_valid_o(ea_valid_o), .xwr_en_o(xwr_en_o), .xwr_data_o(xwr_data_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] v16(int i);
    case (i % 8)
      0: return 16'h0000; 1: return 16'hFFFF; 2: return 16'hFF80; 3: return 16'h8000;
      4: return 16'h7FFF; 5: return 16'h0001; 6: return 16'h1234; default: return 16'hFFF0;
    endcase
  endfunction

  function automatic logic [19:0] o20(int i);
    case (i % 8)
      0: return 20'h00000; 1: return 20'h000FF; 2: return 20'h00080; 3: return 20'h0FFFF;
      4: return 20'h08000; 5: return 20'hFFFFF; 6: return 20'h80000; default: return 20'h17F7F;
    endcase
  endfunction

  function automatic longint sgn(longint v, int bits);
    longint m = longint'(1) << bits;
    return (v >= m / 2) ? v - m : v;
  endfunction

  function automatic string req_of(int m);
    case (m)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    longint T20 = 1048576, T16 = 65536;
    rst_n = 0; valid_i = 0; taken_i = 0; mode_i = 0; idx_sel_i = 0;
    ix_i = 16'hABCD; iy_i = 0; iz_i = 0; acc_i = 0; pc_i = 0;
    xk_i = 0; yk_i = 0; zk_i = 0; pk_i = 0; ek_i = 4'hC; ofs_i = 20'h12345;
    repeat (3) @(negedge clk);
    valid_i = 1;
    @(negedge clk);
    chk("R11 ea", ea_o, 0); chk("R11 valid", ea_valid_o, 0);
    chk("R11 wen", xwr_en_o, 0); chk("R11 wdata", xwr_data_o, 0);
    valid_i = 0; rst_n = 1;
    @(negedge clk);
    chk("R1 idle valid", ea_valid_o, 0);

    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 8; a++)
          for (int b = 0; b < 8; b++) begin
            longint base, low, e, wd;
            int sel;
            mode_i = 3'(m); idx_sel_i = 2'(s);
            ix_i = v16(a); iy_i = v16(a + 3); iz_i = v16(a + 5);
            xk_i = 4'(a * 7); yk_i = 4'(a * 7 + 5); zk_i = 4'(15 - a);
            acc_i = v16(b); pc_i = v16(7 - a + b); pk_i = 4'(a + b);
            ek_i = 4'(b * 3 + a); ofs_i = o20(b + s);
            taken_i = 1'(a ^ b);
            valid_i = 1;
            sel = (s > 2) ? 2 : s;
            base = (sel == 0) ? longint'(xk_i) * T16 + ix_i :
                   (sel == 1) ? longint'(yk_i) * T16 + iy_i :
                                longint'(zk_i) * T16 + iz_i;
            case (m)
              0: e = longint'(ek_i) * T16 + (ofs_i % T16);
              1: e = (base + (ofs_i % 256)) % T20;
              2: e = (base + sgn(ofs_i % T16, 16) + T20) % T20;
              3: e = (base + sgn(ofs_i, 20) + T20) % T20;
              4: e = (base + acc_i) % T20;
              5, 6: begin
                low = taken_i ? (pc_i + sgn((m == 5) ? ofs_i % 256 : ofs_i % T16,
                                            (m == 5) ? 8 : 16) + T16) % T16 : pc_i;
                e = longint'(pk_i) * T16 + low;
              end
              default: e = longint'(xk_i) * T16 + ix_i;
            endcase
            wd = (ix_i + sgn(ofs_i % 256, 8) + T16) % T16;
            @(negedge clk);
            chk({req_of(m), " R9 ea"}, ea_o, e);
            chk("R1 valid", ea_valid_o, 1);
            chk("R8 wen", xwr_en_o, (m == 7) ? 1 : 0);
            if (m == 7) chk("R8 wdata", xwr_data_o, wd);
            valid_i = 0; mode_i = 3'(7 - m); ix_i = ~ix_i; ofs_i = ~ofs_i; ek_i = ~ek_i;
            pc_i = ~pc_i; taken_i = ~taken_i;
            @(negedge clk);
            chk("R10 hold ea", ea_o, e);
            chk("R10 valid low", ea_valid_o, 0);
            chk("R10 wen low", xwr_en_o, 0);
          end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule